// File: doc/BRIEF.md
# Time-Slot Serial Byte Sequencer

This block runs a short programmable list of time slots that together push one 32-bit word out over a gated serial clock and data line. Three word-select lines pick the target device. Each of the slot records chooses four things: whether the slot shifts a byte, which byte of the output buffer it sends, which word-select line it raises, and where it takes the returning bit from. A record may also end the list. Slot 1 is the load slot. It takes the next word from a small input FIFO and places it in the output buffer. Every shifted slot captures one byte into the top of a feedback register.

A controller uses the block as follows. It sets the end flag on slot 0 so the list parks there. It writes a word into the FIFO and opens the output gate with a one-cycle enable pulse. It then clears the end flag on slot 0 to start a pass, and sets the flag again before the list wraps. When the list wraps back to slot 0, the gate closes by itself, so at most one pass reaches the pins. Two things mark the end of a pass: the `held` status, and a sentinel byte in the feedback register. The sentinel is 0xFF when a slot samples a pulled-up input, and 0x00 when a slot loops back a zero byte.

Top module: `tslot_seq`

## Requirements
- R1: Out of synchronous reset, `sclk`, `sdo` and `ws` are low, `udf` and `ovf` are clear, `fb` is zero, and `held` is high because slot 0 resets with its end flag set.
- R2: Slots run in increasing order from 0. Finishing the last slot (5), or any slot 1 to 4 whose end flag is set, returns execution to slot 0.
- R3: While slot 0's end flag is set, slot 0 repeats and `held` stays high. Nothing reaches the pins, and a non-shifting slot 0 leaves `fb` unchanged.
- R4: Slot 1 pops one FIFO word into the output buffer. If the FIFO holds one word or none at that moment, the sticky `udf` flag is set; an empty FIFO leaves the buffer unchanged. `flag_clr` clears the flag.
- R5: The FIFO holds FIFO_DEPTH words. A write to a full FIFO is dropped and sets the sticky `ovf` flag, which `flag_clr` clears.
- R6: Record bit layout: bit 0 is shift enable; bits 2:1 are the byte index k, which sends buffer bits 8k+7..8k; bits 4:3 are the word-select code, where code c from 1 to 3 raises `ws[c-1]` and code 0 raises none; bit 5 selects `sdi` (1) or loop-back of the own transmitted bit (0); bit 6 is the end flag. A shifting slot in 0 or 2..5 sends its byte MSB first as 8 clock pulses.
- R7: `sclk` idles low. In each bit period of DIV cycles it is high for the second half, and `sdo` does not change while `sclk` is high.
- R8: When the list returns from another slot to slot 0, the output gate closes and `sclk`, `sdo` and `ws` stay low. Slots keep running internally while the gate is closed. A `gate_en` pulse reopens the gate.
- R9: Each shifted byte enters `fb[31:24]` and older bytes move down by one byte. A pulled-up `sdi` gives 0xFF, and loop-back gives the transmitted byte.
- R10: A record write takes effect the next time that slot begins. A slot already running keeps the record it started with.
- R11: A slot other than 1 with shift enable clear lasts one cycle and emits no clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_we | input | 1 | Slot record write strobe |
| rec_addr | input | 3 | Slot number to write |
| rec_data | input | 7 | Record value (layout in R6) |
| fifo_we | input | 1 | FIFO word write strobe |
| fifo_wdata | input | 32 | FIFO word |
| gate_en | input | 1 | Pulse that opens the output gate |
| flag_clr | input | 1 | Pulse that clears `udf` and `ovf` |
| sdi | input | 1 | External serial input |
| sclk | output | 1 | Gated serial clock |
| sdo | output | 1 | Gated serial data |
| ws | output | 3 | Gated word-select lines |
| fb | output | 32 | Feedback register |
| udf | output | 1 | Sticky FIFO underflow |
| ovf | output | 1 | Sticky FIFO overflow |
| held | output | 1 | Execution parked at slot 0 |

## Verification
The bench builds the block with DIV = 4 and FIFO_DEPTH = 2. With a short bit period, a full six-slot pass finishes in about 130 cycles, so one run covers several passes. With a depth of two, the third write already hits the overflow case. The second pass runs with the gate closed and drains the FIFO, which leads to the underflow case. The later passes then show the old buffer being reused, a record rewritten while its slot is running, a mid-list end flag and a non-shifting slot.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       eos;
    logic       rx_ext;
    logic [1:0] ws_code;
    logic [1:0] byte_idx;
    logic       shift_en;
  } slot_rec_t;

  localparam int REC_W = $bits(slot_rec_t);
endpackage

// File: rtl/tslot_fifo.sv
module tslot_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic                       drop,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign rdata   = mem[rptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/tslot_recfile.sv
module tslot_recfile
  import tslot_pkg::*;
#(
  parameter int NSLOT = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NSLOT)-1:0] waddr,
  input  slot_rec_t                wdata,
  input  logic [$clog2(NSLOT)-1:0] raddr,
  output slot_rec_t                rdata
);
  slot_rec_t recs [NSLOT];

  assign rdata = recs[raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) begin
        recs[i]     <= '0;
        recs[i].eos <= (i == 0);
      end
    end else if (we && (int'(waddr) < NSLOT)) begin
      recs[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/tslot_engine.sv
module tslot_engine
  import tslot_pkg::*;
#(
  parameter int DIV   = 8,
  parameter int NSLOT = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  slot_rec_t                rec,
  input  logic                     fifo_empty,
  input  logic [WORD_W-1:0]        fifo_rdata,
  input  logic                     sdi,
  input  logic                     gate_en,
  output logic [$clog2(NSLOT)-1:0] cur_slot,
  output logic                     load,
  output logic                     pop,
  output logic                     shifting,
  output logic                     txbit,
  output logic                     sclk_raw,
  output logic [2:0]               ws_raw,
  output logic                     gate_open,
  output logic [WORD_W-1:0]        fb,
  output logic                     held
);
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam int SW   = $clog2(NSLOT);

  slot_rec_t         cur_rec;
  logic [PW-1:0]     phase;
  logic [2:0]        bitn;
  logic [BYTE_W-1:0] rxsh;
  logic [WORD_W-1:0] obuf;
  logic              rxbit, done, eos_sel, last_ph;
  logic [SW-1:0]     nxt;

  assign last_ph  = (phase == PW'(DIV-1));
  assign txbit    = obuf[{cur_rec.byte_idx, ~bitn}];
  assign rxbit    = cur_rec.rx_ext ? sdi : txbit;
  assign sclk_raw = shifting && (phase >= PW'(HALF));
  assign load     = !shifting && (cur_slot == SW'(1));
  assign pop      = load && !fifo_empty;

  generate
    for (genvar i = 0; i < 3; i++) begin : g_ws
      assign ws_raw[i] = shifting && (cur_rec.ws_code == 2'(i+1));
    end
  endgenerate

  always_comb begin
    if (!shifting) begin
      done    = load || !rec.shift_en;
      eos_sel = rec.eos;
    end else begin
      done    = last_ph && (bitn == 3'd7);
      eos_sel = cur_rec.eos;
    end
    if (eos_sel || cur_slot == SW'(NSLOT-1)) nxt = '0;
    else                                     nxt = cur_slot + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_slot  <= '0;
      shifting  <= 1'b0;
      cur_rec   <= '0;
      phase     <= '0;
      bitn      <= '0;
      rxsh      <= '0;
      obuf      <= '0;
      fb        <= '0;
      gate_open <= 1'b0;
      held      <= 1'b1;
    end else begin
      if (!shifting) begin
        if (!load && rec.shift_en) begin
          shifting <= 1'b1;
          cur_rec  <= rec;
          phase    <= '0;
          bitn     <= '0;
        end
        if (pop) obuf <= fifo_rdata;
      end else if (last_ph) begin
        phase <= '0;
        bitn  <= bitn + 3'd1;
        rxsh  <= {rxsh[BYTE_W-2:0], rxbit};
        if (bitn == 3'd7) begin
          shifting <= 1'b0;
          fb       <= {rxsh[BYTE_W-2:0], rxbit, fb[WORD_W-1:BYTE_W]};
        end
      end else begin
        phase <= phase + PW'(1);
      end

      if (done) begin
        cur_slot <= nxt;
        if (cur_slot == '0) held <= (nxt == '0);
      end

      if (done && cur_slot != '0 && nxt == '0) gate_open <= 1'b0;
      else if (gate_en)                        gate_open <= 1'b1;
    end
  end
endmodule

// File: rtl/tslot_seq.sv
module tslot_seq
  import tslot_pkg::*;
#(
  parameter int DIV        = 8,
  parameter int NSLOT      = 6,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rec_we,
  input  logic [$clog2(NSLOT)-1:0] rec_addr,
  input  logic [6:0]               rec_data,
  input  logic                     fifo_we,
  input  logic [31:0]              fifo_wdata,
  input  logic                     gate_en,
  input  logic                     flag_clr,
  input  logic                     sdi,
  output logic                     sclk,
  output logic                     sdo,
  output logic [2:0]               ws,
  output logic [31:0]              fb,
  output logic                     udf,
  output logic                     ovf,
  output logic                     held
);
  localparam int SW = $clog2(NSLOT);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  slot_rec_t         rec_rd;
  logic [SW-1:0]     cur_slot;
  logic [WORD_W-1:0] fifo_rdata;
  logic [LW-1:0]     fifo_level;
  logic              fifo_empty, fifo_drop, load, pop;
  logic              shifting, txbit, sclk_raw, gate_open;
  logic [2:0]        ws_raw;

  tslot_recfile #(.NSLOT(NSLOT)) u_recs (
    .clk(clk), .rst(rst), .we(rec_we), .waddr(rec_addr),
    .wdata(slot_rec_t'(rec_data)), .raddr(cur_slot), .rdata(rec_rd)
  );

  tslot_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_we), .wdata(fifo_wdata),
    .pop(pop), .rdata(fifo_rdata), .empty(fifo_empty),
    .drop(fifo_drop), .level(fifo_level)
  );

  tslot_engine #(.DIV(DIV), .NSLOT(NSLOT)) u_eng (
    .clk(clk), .rst(rst), .rec(rec_rd), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .sdi(sdi), .gate_en(gate_en),
    .cur_slot(cur_slot), .load(load), .pop(pop), .shifting(shifting),
    .txbit(txbit), .sclk_raw(sclk_raw), .ws_raw(ws_raw),
    .gate_open(gate_open), .fb(fb), .held(held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b0;
      sdo  <= 1'b0;
      ws   <= '0;
      udf  <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      sclk <= gate_open && sclk_raw;
      sdo  <= gate_open && shifting && txbit;
      ws   <= gate_open ? ws_raw : 3'b000;
      udf  <= (udf && !flag_clr) || (load && (fifo_level <= LW'(1)));
      ovf  <= (ovf && !flag_clr) || fifo_drop;
    end
  end
endmodule

// File: rtl/tslot_chk.sv
module tslot_chk #(
  parameter int NSLOT = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sclk,
  input logic                     sdo,
  input logic [2:0]               ws,
  input logic                     udf,
  input logic                     ovf,
  input logic                     flag_clr,
  input logic [$clog2(NSLOT)-1:0] cur_slot,
  input logic                     gate_open
);
  localparam int SW = $clog2(NSLOT);

  assert_ws_single_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ws));

  assert_sdo_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo));

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_slot != $past(cur_slot)) |->
      (cur_slot == $past(cur_slot) + SW'(1) || cur_slot == '0));

  assert_slot_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(cur_slot) < NSLOT);

  assert_gate_shut_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(cur_slot) != '0 && cur_slot == '0) |-> !gate_open);

  assert_udf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(udf) && !$past(flag_clr)) |-> udf);

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf) && !$past(flag_clr)) |-> ovf);
endmodule

bind tslot_seq tslot_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .sdo(sdo), .ws(ws), .udf(udf),
  .ovf(ovf), .flag_clr(flag_clr), .cur_slot(cur_slot), .gate_open(gate_open)
);

// File: tb/tb_tslot_seq.sv
`timescale 1ns/1ps
module tb_tslot_seq;
  localparam int DIV = 4;
  localparam int NSLOT = 6;
  localparam int FD = 2;
  localparam logic [31:0] WA = 32'hC35A960F;
  localparam logic [31:0] WB = 32'h81007E24;
  localparam logic [31:0] WC = 32'hDEADBEEF;

  logic clk = 1'b0, rst = 1'b1;
  logic rec_we = 0, fifo_we = 0, gate_en = 0, flag_clr = 0, sdi = 1'b1;
  logic [2:0] rec_addr = '0;
  logic [6:0] rec_data = '0;
  logic [31:0] fifo_wdata = '0;
  logic sclk, sdo, udf, ovf, held;
  logic [2:0] ws;
  logic [31:0] fb;

  int checks = 0, errors = 0, edges = 0, ws_seen = 0, nb = 0;
  logic [7:0] shreg = '0;
  logic prev_sclk = 1'b0;
  logic [10:0] exp_q[$];

  always #4 clk = ~clk;

  tslot_seq #(.DIV(DIV), .NSLOT(NSLOT), .FIFO_DEPTH(FD)) dut (
    .clk(clk), .rst(rst), .rec_we(rec_we), .rec_addr(rec_addr),
    .rec_data(rec_data), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
    .gate_en(gate_en), .flag_clr(flag_clr), .sdi(sdi), .sclk(sclk),
    .sdo(sdo), .ws(ws), .fb(fb), .udf(udf), .ovf(ovf), .held(held)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input logic sh, input logic [1:0] idx,
                                    input logic [1:0] wsc, input logic rx, input logic eos);
    return {eos, rx, wsc, idx, sh};
  endfunction

  // monitor: rebuild bytes at sclk rising edges and compare with scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (ws != 3'b000) ws_seen++;
      if (sclk && !prev_sclk) begin
        edges++;
        shreg = {shreg[6:0], sdo};
        nb++;
        if (nb == 8) begin
          nb = 0;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R6 unexpected byte actual=%h expected=none", {ws, shreg});
          end else begin
            logic [10:0] e;
            e = exp_q.pop_front();
            if (e !== {ws, shreg}) begin
              errors++;
              $display("FAIL R6 byte actual=%h expected=%h", {ws, shreg}, e);
            end
          end
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic pulse_rec(input int a, input logic [6:0] d);
    rec_addr = 3'(a); rec_data = d; rec_we = 1'b1;
    @(negedge clk); rec_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    fifo_wdata = w; fifo_we = 1'b1;
    @(negedge clk); fifo_we = 1'b0;
  endtask

  task automatic pulse_gate();
    gate_en = 1'b1; @(negedge clk); gate_en = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
  endtask

  task automatic expect_byte(input logic [2:0] w, input logic [7:0] b);
    exp_q.push_back({w, b});
  endtask

  task automatic wait_held(input logic v, input string tag);
    int n = 0;
    while (held !== v && n < 5000) begin @(negedge clk); n++; end
    check(n < 5000, tag, {31'd0, held}, {31'd0, v});
  endtask

  task automatic release_slot0();
    pulse_rec(0, mk(0, 0, 0, 0, 0));
    wait_held(1'b0, "R3 release");
    pulse_rec(0, mk(0, 0, 0, 0, 1));
  endtask

  task automatic run_pass();
    release_slot0();
    wait_held(1'b1, "R2 wrap");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    logic [31:0] fb0, efb;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({sclk, sdo, ws} == 5'b0, "R1 pins", {27'd0, sclk, sdo, ws}, 0);
    check(!udf && !ovf, "R1 flags", {30'd0, udf, ovf}, 0);
    check(fb == 0, "R1 fb", fb, 0);
    check(held == 1'b1, "R1 held", {31'd0, held}, 1);

    // R5 overflow on third write
    push(WA); push(WB);
    @(negedge clk);
    check(!ovf, "R5 no ovf", {31'd0, ovf}, 0);
    push(WC);
    @(negedge clk);
    check(ovf, "R5 ovf set", {31'd0, ovf}, 1);
    pulse_clr();
    check(!ovf, "R5 ovf clear", {31'd0, ovf}, 0);

    // program slots: sdi capture
    pulse_rec(1, mk(0, 0, 0, 0, 0));
    pulse_rec(2, mk(1, 3, 1, 1, 0));
    pulse_rec(3, mk(1, 2, 1, 1, 0));
    pulse_rec(4, mk(1, 1, 3, 1, 0));
    pulse_rec(5, mk(1, 0, 3, 1, 1));

    // pass 1: word A with gate open
    pulse_gate();
    expect_byte(3'b001, WA[31:24]); expect_byte(3'b001, WA[23:16]);
    expect_byte(3'b100, WA[15:8]);  expect_byte(3'b100, WA[7:0]);
    e0 = edges;
    run_pass();
    check(exp_q.size() == 0, "R6 pass1 bytes", exp_q.size(), 0);
    check(edges - e0 == 32, "R7 pass1 clocks", edges - e0, 32);
    check(fb == 32'hFFFFFFFF, "R9 pulled-up sentinel", fb, 32'hFFFFFFFF);
    check(!udf, "R4 word left", {31'd0, udf}, 0);
    check(!sclk && ws == 0, "R7 idle low", {28'd0, sclk, ws}, 0);

    // R3 trapped: nothing moves
    e0 = edges; fb0 = fb;
    repeat (60) @(negedge clk);
    check(edges == e0 && held, "R3 trap quiet", edges - e0, 0);
    check(fb == fb0, "R3 fb stable", fb, fb0);

    // pass 2: gate closed, loop-back capture, FIFO drained
    pulse_rec(2, mk(1, 3, 1, 0, 0));
    pulse_rec(3, mk(1, 2, 1, 0, 0));
    pulse_rec(4, mk(1, 1, 3, 0, 0));
    pulse_rec(5, mk(1, 0, 3, 0, 1));
    e0 = edges; fb0 = 32'(ws_seen);
    run_pass();
    check(edges == e0, "R8 gate shut clocks", edges - e0, 0);
    check(32'(ws_seen) == fb0, "R8 gate shut ws", ws_seen, fb0);
    efb = {WB[7:0], WB[15:8], WB[23:16], WB[31:24]};
    check(fb == efb, "R9 loop-back", fb, efb);
    check(udf, "R4 underflow set", {31'd0, udf}, 1);

    // pass 3: empty FIFO reuses buffer; rewrite slot 3 while it runs
    pulse_gate();
    expect_byte(3'b001, WB[31:24]); expect_byte(3'b001, WB[23:16]);
    expect_byte(3'b100, WB[15:8]);  expect_byte(3'b100, WB[7:0]);
    e0 = edges;
    release_slot0();
    begin
      int n = 0;
      while (edges < e0 + 10 && n < 5000) begin @(negedge clk); n++; end
    end
    pulse_rec(3, mk(1, 0, 2, 0, 0));
    wait_held(1'b1, "R2 wrap pass3");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 old record kept", exp_q.size(), 0);
    check(fb == efb, "R4 buffer kept", fb, efb);

    // pass 4: slot 2 idle, end flag in slot 4, no word-select
    pulse_rec(2, mk(0, 3, 1, 0, 0));
    pulse_rec(4, mk(1, 1, 0, 0, 1));
    pulse_gate();
    expect_byte(3'b010, WB[7:0]); expect_byte(3'b000, WB[15:8]);
    e0 = edges;
    run_pass();
    check(exp_q.size() == 0, "R10 R11 pass4 bytes", exp_q.size(), 0);
    check(edges - e0 == 16, "R11 R2 clocks", edges - e0, 16);
    efb = {WB[15:8], WB[7:0], efb[31:16]};
    check(fb == efb, "R9 shift order", fb, efb);
    check(udf, "R4 sticky", {31'd0, udf}, 1);
    pulse_clr();
    check(!udf, "R4 clear", {31'd0, udf}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule